// File: doc/BRIEF.md
# Two-Tone Bit Demodulator with Frame Lock

This block recovers a bit stream from a one-bit, already thresholded input that toggles at one of two subcarrier rates. A sample-clock enable marks the ticks of the sampling grid. The block counts rising edges of the input. On every sixteenth edge it makes a decision. The number of enabled ticks since the previous decision is the measured duration of the group. A short group means the high subcarrier rate, and a long group means the low one.

Each decision is a one, a zero, or a rejection. A one comes from the low-rate window and a zero from the high-rate window. A rejection wipes the whole 128-bit history register. Bits arrive least significant first, so every accepted bit enters at the top of the register and the older content moves down by one place. When a shift leaves a sync signature at the bottom of the register, and the byte just above that signature matches a byte near the top, the block flags a frame for one cycle. It then holds the register still until it is cleared, so the captured frame can be read at leisure. The expected group lengths and the tolerance are taken from inputs when `start` is pulsed.

Top module: `fsk_frame_demod`

## Requirements
- R1: After `rst_n` is low, or in the cycle after `clear` is high, `shreg` is all zeros and `frame_valid` is low. The edge counter, the tick counter and any frame lock are also released.
- R2: `lo_count`, `hi_count` and `tol` take effect only in a cycle where `start` is high. Changing them while `start` is low leaves the decoding unchanged.
- R3: Only clocks with `sample_en` high count as ticks, and `sub_in` is looked at only on those clocks. A decision is made on every 16th rising edge of `sub_in`. Its measured value is the number of ticks since the previous decision, the deciding tick included.
- R4: A measured value strictly between `lo_count - tol` and `lo_count + tol` shifts a 1 into bit 127. Bits 127..1 move to bits 126..0.
- R5: A measured value strictly between `hi_count - tol` and `hi_count + tol` (and not in the R4 window) shifts a 0 into bit 127 in the same way.
- R6: The window edges are exclusive. A measured value that is in neither window sets all 128 bits of `shreg` to zero.
- R7: When the two windows overlap, a value inside both is decoded as 1.
- R8: A frame is found after a shift when bits [22:0] equal 0x7E0000 and bits [23:16] equal bits [111:104]. `frame_valid` is then high for exactly one cycle, and in that cycle `shreg` already holds the frame.
- R9: After a frame is found, `shreg` stays unchanged and no further `frame_valid` pulse occurs, whatever `sub_in` does, until `clear` is asserted.
- R10: A shift that produces the sync signature with a mismatching byte pair raises no `frame_valid`, and decoding continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous return of counters, register and lock to zero |
| start | input | 1 | Captures `lo_count`, `hi_count` and `tol` |
| lo_count | input | 12 | Expected ticks per group at the low subcarrier rate (decodes to 1) |
| hi_count | input | 12 | Expected ticks per group at the high subcarrier rate (decodes to 0) |
| tol | input | 12 | Half-width of both acceptance windows, exclusive |
| sample_en | input | 1 | Sample tick enable |
| sub_in | input | 1 | Thresholded subcarrier input |
| shreg | output | 128 | Bit history, newest bit at position 127 |
| frame_valid | output | 1 | One-cycle strobe when a frame is locked |

## Verification
The hardest state to reach from the ports is a lock on a full frame. It needs 128 consecutive accepted groups whose bit order places the sync signature and the matching byte pair in the right place, with no earlier partial shift that already looks like a frame. The stimulus builds one 128-bit word whose filler cannot form seventeen zeros. It emits that word least significant bit first, as groups of sixteen subcarrier cycles, with the group length chosen tick by tick. A second word differs only in the upper byte, and it drives the mismatch case. Window edges are reached by spreading a remainder of single extra ticks across the cycles of a group. This gives measured values exactly at and next to each window bound.

// File: rtl/fsk_frame_demod.sv
module fsk_frame_demod #(
  parameter int SR_W        = 128,
  parameter int CNT_W       = 12,
  parameter int CYC_PER_BIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic [CNT_W-1:0] lo_count,
  input  logic [CNT_W-1:0] hi_count,
  input  logic [CNT_W-1:0] tol,
  input  logic             sample_en,
  input  logic             sub_in,
  output logic [SR_W-1:0]  shreg,
  output logic             frame_valid
);
  localparam int EW       = $clog2(CYC_PER_BIT);
  localparam logic [EW-1:0] LAST_EDGE = EW'(CYC_PER_BIT - 1);
  localparam int SYNC_W   = 23;
  localparam logic [SYNC_W-1:0] SYNC_PAT = 23'h7E0000;
  localparam int HEAD_LSB = 16;
  localparam int TAIL_LSB = SR_W - 24;

  logic [CNT_W-1:0] cfg_lo, cfg_hi, cfg_tol;
  logic [CNT_W-1:0] tick_cnt;
  logic [EW-1:0]    edge_cnt;
  logic             prev_in;
  logic             frozen;

  logic             live, rise, decide, in_lo, in_hi, hit;
  logic [CNT_W-1:0] tick_inc;
  logic [CNT_W:0]   meas_x, meas_p, lo_p, hi_p;
  logic [SR_W-1:0]  nxt_sr;

  assign live     = sample_en && !frozen;
  assign rise     = sub_in && !prev_in;
  assign decide   = live && rise && (edge_cnt == LAST_EDGE);
  assign tick_inc = (&tick_cnt) ? tick_cnt : tick_cnt + 1'b1;

  assign meas_x = {1'b0, tick_inc};
  assign meas_p = meas_x + {1'b0, cfg_tol};
  assign lo_p   = {1'b0, cfg_lo} + {1'b0, cfg_tol};
  assign hi_p   = {1'b0, cfg_hi} + {1'b0, cfg_tol};
  assign in_lo  = (meas_p > {1'b0, cfg_lo}) && (meas_x < lo_p);
  assign in_hi  = (meas_p > {1'b0, cfg_hi}) && (meas_x < hi_p);

  always_comb begin
    if (in_lo)      nxt_sr = {1'b1, shreg[SR_W-1:1]};
    else if (in_hi) nxt_sr = {1'b0, shreg[SR_W-1:1]};
    else            nxt_sr = '0;
  end

  assign hit = decide && (in_lo || in_hi)
            && (nxt_sr[SYNC_W-1:0] == SYNC_PAT)
            && (nxt_sr[HEAD_LSB +: 8] == nxt_sr[TAIL_LSB +: 8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lo  <= '0;
      cfg_hi  <= '0;
      cfg_tol <= '0;
    end else if (start) begin
      cfg_lo  <= lo_count;
      cfg_hi  <= hi_count;
      cfg_tol <= tol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt    <= '0;
      edge_cnt    <= '0;
      prev_in     <= 1'b0;
      frozen      <= 1'b0;
      shreg       <= '0;
      frame_valid <= 1'b0;
    end else if (clear) begin
      tick_cnt    <= '0;
      edge_cnt    <= '0;
      prev_in     <= 1'b0;
      frozen      <= 1'b0;
      shreg       <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= hit;
      if (hit) frozen <= 1'b1;
      if (live) begin
        prev_in <= sub_in;
        if (decide) begin
          tick_cnt <= '0;
          edge_cnt <= '0;
          shreg    <= nxt_sr;
        end else begin
          tick_cnt <= tick_inc;
          if (rise) edge_cnt <= edge_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsk_frame_demod_chk.sv
module fsk_frame_demod_chk #(
  parameter int SR_W = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear,
  input logic            sample_en,
  input logic [SR_W-1:0] shreg,
  input logic            frame_valid
);
  logic locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           locked <= 1'b0;
    else if (clear)       locked <= 1'b0;
    else if (frame_valid) locked <= 1'b1;
  end

  // R1: clear empties the register and drops the strobe
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (shreg == '0) && !frame_valid);

  // R3: with no sample tick nothing moves
  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !clear) |=> $stable(shreg) && !frame_valid);

  // R4, R5, R6: register only holds, shifts by one, or empties
  a_r6_shift_or_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> $stable(shreg) || (shreg == '0)
               || (shreg[SR_W-2:0] == $past(shreg[SR_W-1:1])));

  // R8: strobe only with the signature and matching bytes present
  a_r8_frame_shape: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (shreg[22:0] == 23'h7E0000)
                    && (shreg[23:16] == shreg[SR_W-17:SR_W-24]));

  // R8: strobe lasts a single cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R9: locked register stays put until clear
  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear) |=> $stable(shreg) && !frame_valid);
endmodule

bind fsk_frame_demod fsk_frame_demod_chk #(.SR_W(SR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .sample_en(sample_en),
  .shreg(shreg), .frame_valid(frame_valid)
);

// File: tb/fsk_frame_demod_tb.sv
module fsk_frame_demod_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, clear, start, sample_en, sub_in;
  logic [11:0]  lo_count, hi_count, tol;
  logic [127:0] shreg;
  logic         frame_valid;

  fsk_frame_demod u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
    .lo_count(lo_count), .hi_count(hi_count), .tol(tol),
    .sample_en(sample_en), .sub_in(sub_in),
    .shreg(shreg), .frame_valid(frame_valid)
  );

  int checks = 0, errors = 0, fv_cnt = 0, div = 1;
  int cfg_lo, cfg_hi, cfg_tol;
  logic [127:0] m_sr;
  bit m_frz;
  int m_fv = 0;

  always @(posedge clk) if (rst_n && frame_valid) fv_cnt++;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(shreg == m_sr, req, shreg, m_sr);
    chk(fv_cnt == m_fv, {req, " strobe count"}, 128'(fv_cnt), 128'(m_fv));
  endtask

  task automatic tick(input logic v);
    for (int i = 1; i < div; i++) begin
      @(negedge clk); sample_en = 1'b0; sub_in = ~v;
    end
    @(negedge clk); sample_en = 1'b1; sub_in = v;
  endtask

  task automatic cyc(input int p);
    for (int i = 0; i < p / 2; i++) tick(1'b1);
    for (int i = 0; i < p - p / 2; i++) tick(1'b0);
  endtask

  function automatic int cls(input int m);
    if (m > cfg_lo - cfg_tol && m < cfg_lo + cfg_tol) return 1;
    if (m > cfg_hi - cfg_tol && m < cfg_hi + cfg_tol) return 0;
    return 2;
  endfunction

  task automatic model(input int c);
    if (m_frz) return;
    if (c == 2) m_sr = '0;
    else begin
      m_sr = {c[0], m_sr[127:1]};
      if (m_sr[22:0] == 23'h7E0000 && m_sr[23:16] == m_sr[111:104]) begin
        m_frz = 1'b1;
        m_fv++;
      end
    end
  endtask

  task automatic group(input int m);
    for (int i = 0; i < 16; i++) cyc((i < m % 16) ? m / 16 + 1 : m / 16);
    model(cls(m));
  endtask

  task automatic send_bit(input logic b);
    group(b ? cfg_lo : cfg_hi);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1; sample_en = 1'b0; sub_in = 1'b0;
    @(negedge clk); clear = 1'b0;
    m_sr = '0; m_frz = 1'b0;
  endtask

  task automatic sync_start();
    do_clear();
    for (int i = 0; i < 100; i++) tick(1'b0);
    for (int i = 0; i < 15; i++) cyc(17);
  endtask

  task automatic tail();
    tick(1'b1);
    for (int i = 0; i < 3; i++) tick(1'b0);
    @(negedge clk); sample_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input int lo, input int hi, input int tl);
    @(negedge clk);
    lo_count = 12'(lo); hi_count = 12'(hi); tol = 12'(tl); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cfg_lo = lo; cfg_hi = hi; cfg_tol = tl;
  endtask

  task automatic t_reset();
    chk(shreg == '0, "R1 reset shreg", shreg, '0);
    chk(frame_valid == 1'b0, "R1 reset frame_valid", 128'(frame_valid), '0);
  endtask

  task automatic t_basic();
    sync_start();
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    send_bit(0); send_bit(0); send_bit(1); send_bit(0);
    tail();
    chk_state("R4 R5 ones and zeros");
    chk(shreg[127:120] == 8'b0100_1101, "R4 R5 top byte", 128'(shreg[127:120]), 128'h4D);
  endtask

  task automatic t_invalid();
    sync_start();
    send_bit(1); send_bit(1); group(208);
    tail();
    chk(shreg == '0, "R6 off-window wipe", shreg, '0);
  endtask

  task automatic t_bounds();
    sync_start();
    group(279); group(265); group(233); group(247);
    tail();
    chk_state("R4 R5 inside edges");
    chk(shreg[127:124] == 4'b0011, "R4 R5 inside edges bits", 128'(shreg[127:124]), 128'h3);
    sync_start(); group(279); group(280); tail();
    chk(shreg == '0, "R6 upper lo bound", shreg, '0);
    sync_start(); group(279); group(264); tail();
    chk(shreg == '0, "R6 lower lo bound", shreg, '0);
    sync_start(); group(279); group(248); tail();
    chk(shreg == '0, "R6 upper hi bound", shreg, '0);
  endtask

  task automatic t_start_gate();
    @(negedge clk); lo_count = 12'd100; hi_count = 12'd50; tol = 12'd2;
    sync_start();
    group(272); group(240);
    tail();
    chk_state("R2 unlatched config ignored");
    chk(shreg[127:126] == 2'b01, "R2 bits", 128'(shreg[127:126]), 128'h1);
  endtask

  task automatic t_overlap();
    set_cfg(260, 262, 8);
    sync_start();
    group(261); group(268);
    tail();
    chk_state("R7 overlap priority");
    chk(shreg[127:126] == 2'b01, "R7 bits", 128'(shreg[127:126]), 128'h1);
    set_cfg(272, 240, 8);
  endtask

  task automatic t_enable();
    div = 3;
    sync_start();
    group(272); group(240); group(272);
    tail();
    div = 1;
    chk_state("R3 gated ticks");
    chk(shreg[127:125] == 3'b101, "R3 bits", 128'(shreg[127:125]), 128'h5);
  endtask

  task automatic t_frame();
    logic [127:0] pat;
    int fv0;
    pat = {16'hAAAA, 8'h7E, 80'hAAAA_AAAA_AAAA_AAAA_AAAA, 24'h7E0000};
    fv0 = fv_cnt;
    m_fv = fv0;
    sync_start();
    for (int i = 0; i < 128; i++) send_bit(pat[i]);
    send_bit(1); send_bit(0);
    tail();
    chk(shreg == pat, "R8 frame content", shreg, pat);
    chk(fv_cnt == fv0 + 1, "R8 one strobe", 128'(fv_cnt), 128'(fv0 + 1));
    chk_state("R9 frozen after lock");
    for (int i = 0; i < 20; i++) cyc(13);
    tail();
    chk(shreg == pat, "R9 off-window ignored while locked", shreg, pat);
    do_clear();
    @(negedge clk);
    chk(shreg == '0, "R1 clear releases lock", shreg, '0);
    for (int i = 0; i < 100; i++) tick(1'b0);
    for (int i = 0; i < 15; i++) cyc(17);
    send_bit(1); send_bit(1);
    tail();
    chk_state("R1 decoding resumes after clear");
  endtask

  task automatic t_mismatch();
    logic [127:0] pat;
    int fv0;
    pat = {16'hAAAA, 8'h55, 80'hAAAA_AAAA_AAAA_AAAA_AAAA, 24'h7E0000};
    fv0 = fv_cnt;
    m_fv = fv0;
    sync_start();
    for (int i = 0; i < 128; i++) send_bit(pat[i]);
    tail();
    chk(shreg == pat, "R10 content", shreg, pat);
    chk(fv_cnt == fv0, "R10 no strobe", 128'(fv_cnt), 128'(fv0));
  endtask

  initial begin
    rst_n = 1'b0; clear = 1'b0; start = 1'b0; sample_en = 1'b0; sub_in = 1'b0;
    lo_count = '0; hi_count = '0; tol = '0;
    m_sr = '0; m_frz = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    set_cfg(272, 240, 8);
    t_basic();
    t_invalid();
    t_bounds();
    t_start_gate();
    t_overlap();
    t_enable();
    t_frame();
    t_mismatch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule